// File: doc/BRIEF.md
# Eight-Bit Accumulator Arithmetic/Logic Unit with Flag File

This block is the arithmetic and logic slice of a small eight-bit processor core. It holds the accumulator and a five-bit flag register. In every clock where the enable is high, it applies one operation to the accumulator. Some operations also take a second operand from the operand input. The result goes back into the accumulator. The operation's flag outcome goes into the flag register in the same edge. The adder's carry input and the decimal-adjust step read the carry and auxiliary-carry flags that this register already holds.

The unit has arithmetic, logic, rotate and decimal operations:
- Arithmetic: add, add with carry, subtract, and compare. Compare only sets flags.
- Logic: bitwise AND, OR and XOR, plus complement.
- Rotates: one-bit rotate left and one-bit rotate right through the wrap-around path.
- Decimal adjust: turns the binary sum of two packed-BCD bytes into a valid two-digit packed-BCD value.
- Load: moves the operand into the accumulator without touching the flags.

Instruction decode, memory and the general register file sit outside the block.

Top module: `acc_alu8`

## Requirements
- R1: While rst_n is low and after it is released, acc_o reads 0 and flags_o reads 0. flags_o bit positions are: bit 4 sign, bit 3 zero, bit 2 auxiliary carry, bit 1 parity, bit 0 carry.
- R2: Operation codes on op_i are: 0 add, 1 add with carry, 2 subtract, 3 compare, 4 AND, 5 OR, 6 XOR, 7 complement, 8 rotate left, 9 rotate right, 10 decimal adjust, 11 load. Codes 12 to 15 change nothing. When en_i is low, accumulator and flags keep their values.
- R3: Add (0) and add with carry (1) write acc + opnd (+ the held carry flag, for code 1) modulo 256. Carry is set to the carry out of bit 7. Auxiliary carry is set to the carry out of bit 3.
- R4: Subtract (2) writes acc - opnd modulo 256. Carry is set when opnd > acc (borrow). Auxiliary carry is set when the low nibble of opnd is greater than the low nibble of acc.
- R5: Compare (3) sets every flag exactly as subtract would, and leaves the accumulator unchanged.
- R6: AND, OR and XOR combine the accumulator bitwise with opnd_i. They clear carry and auxiliary carry.
- R7: Complement (7) inverts every accumulator bit. All five flags are left unchanged.
- R8: Rotate left (8) moves bit 7 into bit 0, and rotate right (9) moves bit 0 into bit 7. In both cases the bit that wraps around is copied into carry, and the other four flags are unchanged.
- R9: Decimal adjust (10) proceeds in two steps. First it adds 0x06 when the low nibble is above 9 or auxiliary carry is set; auxiliary carry becomes the carry out of bit 3 of that addition. It then adds 0x60 when the resulting high nibble is above 9, or carry is set, or the first addition overflowed bit 7; carry is set exactly in that case.
- R10: Load (11) copies opnd_i into the accumulator and leaves all flags unchanged.
- R11: For codes 0 to 6 and 10, sign copies result bit 7. Zero is set when the 8-bit result is 0. Parity is set when the result has an even number of ones. For compare, the result is the difference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Apply op_i at this edge |
| op_i | input | 4 | Operation code |
| opnd_i | input | 8 | Second operand / load value |
| acc_o | output | 8 | Accumulator register |
| flags_o | output | 5 | Flag register {sign, zero, aux, parity, carry} |

## Verification
Every result appears one cycle after its stimulus. Operands and the code sampled at a rising edge show up on acc_o and flags_o right after that same edge. The flag inputs that feed the next operation are the ones visible at that moment. The bench therefore drives a vector just after a falling edge and advances its behavioural model by one step. It then compares both outputs at the following falling edge, half a period clear of the edge that loads them. The checker's properties use the same single-cycle |=> relation against the values sampled at the launching edge.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_CMP = 4'd3,
      OP_AND = 4'd4,
      OP_OR  = 4'd5,
      OP_XOR = 4'd6,
      OP_NOT = 4'd7,
      OP_ROL = 4'd8,
      OP_ROR = 4'd9,
      OP_DAA = 4'd10,
      OP_LDA = 4'd11
   } alu_op_e;

   localparam int FLAG_W = 5;

   typedef struct packed {
      logic sign;
      logic zero;
      logic aux;
      logic par;
      logic cy;
   } flags_t;

endpackage

// File: rtl/acc_alu8_addsub.sv
module acc_alu8_addsub #(
   parameter int DATA_W      = 8,
   parameter bit SPLIT_ADDER = 1'b1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cy_o,
   output logic              aux_o
);
   localparam int LO_W = 4;
   localparam int HI_W = DATA_W - LO_W;

   logic [DATA_W-1:0] b_eff;
   logic              c_in;
   logic              c_mid;
   logic              c_top;

   assign b_eff = sub_i ? ~b_i : b_i;
   assign c_in  = sub_i ? ~cin_i : cin_i;

   generate
      if (SPLIT_ADDER) begin : g_split
         logic [LO_W:0] lo_sum;
         logic [HI_W:0] hi_sum;
         assign lo_sum = {1'b0, a_i[LO_W-1:0]} + {1'b0, b_eff[LO_W-1:0]}
                       + {{LO_W{1'b0}}, c_in};
         assign hi_sum = {1'b0, a_i[DATA_W-1:LO_W]} + {1'b0, b_eff[DATA_W-1:LO_W]}
                       + {{HI_W{1'b0}}, lo_sum[LO_W]};
         assign sum_o  = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
         assign c_mid  = lo_sum[LO_W];
         assign c_top  = hi_sum[HI_W];
      end else begin : g_flat
         logic [DATA_W:0] full;
         assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_in};
         assign sum_o = full[DATA_W-1:0];
         assign c_mid = a_i[LO_W] ^ b_eff[LO_W] ^ full[LO_W];
         assign c_top = full[DATA_W];
      end
   endgenerate

   assign cy_o  = sub_i ? ~c_top : c_top;
   assign aux_o = sub_i ? ~c_mid : c_mid;
endmodule

// File: rtl/acc_alu8_bitops.sv
module acc_alu8_bitops import acc_alu8_pkg::*; #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [3:0]        op_i,
   output logic [DATA_W-1:0] res_o,
   output logic              wrap_o
);
   always_comb begin
      res_o  = a_i;
      wrap_o = 1'b0;
      case (op_i)
         OP_AND: res_o = a_i & b_i;
         OP_OR:  res_o = a_i | b_i;
         OP_XOR: res_o = a_i ^ b_i;
         OP_NOT: res_o = ~a_i;
         OP_ROL: begin
            res_o  = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
            wrap_o = a_i[DATA_W-1];
         end
         OP_ROR: begin
            res_o  = {a_i[0], a_i[DATA_W-1:1]};
            wrap_o = a_i[0];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_alu8_decadj.sv
module acc_alu8_decadj #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic              aux_i,
   input  logic              cy_i,
   output logic [DATA_W-1:0] res_o,
   output logic              aux_o,
   output logic              cy_o
);
   localparam logic [3:0]        DIGIT_MAX = 4'd9;
   localparam logic [DATA_W-1:0] LO_FIX    = DATA_W'(8'h06);
   localparam logic [DATA_W-1:0] HI_FIX    = DATA_W'(8'h60);

   logic              lo_big;
   logic              lo_fix;
   logic [DATA_W:0]   mid;
   logic              hi_fix;

   assign lo_big = a_i[3:0] > DIGIT_MAX;
   assign lo_fix = lo_big | aux_i;
   assign mid    = {1'b0, a_i} + {1'b0, (lo_fix ? LO_FIX : '0)};
   assign aux_o  = lo_fix & lo_big;
   assign hi_fix = (mid[7:4] > DIGIT_MAX) | cy_i | mid[DATA_W];
   assign res_o  = mid[DATA_W-1:0] + (hi_fix ? HI_FIX : '0);
   assign cy_o   = hi_fix;
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8 import acc_alu8_pkg::*; #(
   parameter int                DATA_W      = 8,
   parameter logic [DATA_W-1:0] RESET_ACC   = '0,
   parameter bit                SPLIT_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] opnd_i,
   output logic [DATA_W-1:0] acc_o,
   output logic [FLAG_W-1:0] flags_o
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("acc_alu8: decimal adjust needs a two-digit datapath, DATA_W must be 8");
      end
   endgenerate

   logic [DATA_W-1:0] acc_q, acc_d;
   flags_t            flag_q, flag_d;

   logic [DATA_W-1:0] as_sum, bo_res, da_res, res_w;
   logic              as_cy, as_aux, bo_wrap, da_aux, da_cy;
   logic              is_sub, as_cin, szp_upd;
   logic [DATA_W:0]   par_chain;

   assign is_sub = (op_i == OP_SUB) || (op_i == OP_CMP);
   assign as_cin = (op_i == OP_ADC) && flag_q.cy;

   acc_alu8_addsub #(.DATA_W(DATA_W), .SPLIT_ADDER(SPLIT_ADDER)) u_addsub (
      .a_i   (acc_q),
      .b_i   (opnd_i),
      .cin_i (as_cin),
      .sub_i (is_sub),
      .sum_o (as_sum),
      .cy_o  (as_cy),
      .aux_o (as_aux)
   );

   acc_alu8_bitops #(.DATA_W(DATA_W)) u_bitops (
      .a_i    (acc_q),
      .b_i    (opnd_i),
      .op_i   (op_i),
      .res_o  (bo_res),
      .wrap_o (bo_wrap)
   );

   acc_alu8_decadj #(.DATA_W(DATA_W)) u_decadj (
      .a_i   (acc_q),
      .aux_i (flag_q.aux),
      .cy_i  (flag_q.cy),
      .res_o (da_res),
      .aux_o (da_aux),
      .cy_o  (da_cy)
   );

   // result seen by the sign/zero/parity logic
   always_comb begin
      res_w = acc_q;
      case (op_i)
         OP_ADD, OP_ADC, OP_SUB, OP_CMP: res_w = as_sum;
         OP_AND, OP_OR, OP_XOR:          res_w = bo_res;
         OP_DAA:                         res_w = da_res;
         default: ;
      endcase
   end

   assign par_chain[0] = 1'b1;
   generate
      for (genvar gi = 0; gi < DATA_W; gi++) begin : g_par
         assign par_chain[gi+1] = par_chain[gi] ^ res_w[gi];
      end
   endgenerate

   always_comb begin
      acc_d   = acc_q;
      flag_d  = flag_q;
      szp_upd = 1'b0;
      case (op_i)
         OP_ADD, OP_ADC, OP_SUB: begin
            acc_d      = as_sum;
            flag_d.cy  = as_cy;
            flag_d.aux = as_aux;
            szp_upd    = 1'b1;
         end
         OP_CMP: begin
            flag_d.cy  = as_cy;
            flag_d.aux = as_aux;
            szp_upd    = 1'b1;
         end
         OP_AND, OP_OR, OP_XOR: begin
            acc_d      = bo_res;
            flag_d.cy  = 1'b0;
            flag_d.aux = 1'b0;
            szp_upd    = 1'b1;
         end
         OP_NOT: acc_d = bo_res;
         OP_ROL, OP_ROR: begin
            acc_d     = bo_res;
            flag_d.cy = bo_wrap;
         end
         OP_DAA: begin
            acc_d      = da_res;
            flag_d.cy  = da_cy;
            flag_d.aux = da_aux;
            szp_upd    = 1'b1;
         end
         OP_LDA: acc_d = opnd_i;
         default: ;
      endcase
      if (szp_upd) begin
         flag_d.sign = res_w[DATA_W-1];
         flag_d.zero = (res_w == '0);
         flag_d.par  = par_chain[DATA_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= RESET_ACC;
         flag_q <= '0;
      end else if (en_i) begin
         acc_q  <= acc_d;
         flag_q <= flag_d;
      end
   end

   assign acc_o   = acc_q;
   assign flags_o = flag_q;
endmodule

// File: rtl/acc_alu8_chk.sv
module acc_alu8_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en_i,
   input logic [3:0] op_i,
   input logic [7:0] opnd_i,
   input logic [7:0] acc_o,
   input logic [4:0] flags_o
);
   logic szp_op;
   assign szp_op = (op_i <= 4'd6) || (op_i == 4'd10);

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i || op_i >= 4'd12) |=> ($stable(acc_o) && $stable(flags_o)));

   p_cmp_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && op_i == 4'd3) |=> (acc_o == $past(acc_o)));

   p_logic_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && op_i >= 4'd4 && op_i <= 4'd6) |=> (flags_o[0] == 1'b0 && flags_o[2] == 1'b0));

   p_complement_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && op_i == 4'd7) |=> (acc_o == ~$past(acc_o) && flags_o == $past(flags_o)));

   p_rotl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && op_i == 4'd8) |=>
         (acc_o == {$past(acc_o[6:0]), $past(acc_o[7])} && flags_o[0] == $past(acc_o[7])));

   p_rotr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && op_i == 4'd9) |=>
         (acc_o == {$past(acc_o[0]), $past(acc_o[7:1])} && flags_o[0] == $past(acc_o[0])));

   p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && op_i == 4'd11) |=> (acc_o == $past(opnd_i) && flags_o == $past(flags_o)));

   p_sign_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && szp_op && op_i != 4'd3) |=>
         (flags_o[4] == acc_o[7] && flags_o[3] == (acc_o == 8'h00)));

   p_parity_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && szp_op && op_i != 4'd3) |=> (flags_o[1] == ~^acc_o));
endmodule

bind acc_alu8 acc_alu8_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en_i    (en_i),
   .op_i    (op_i),
   .opnd_i  (opnd_i),
   .acc_o   (acc_o),
   .flags_o (flags_o)
);

// File: tb/acc_alu8_bench.sv
`timescale 1ns/1ps
module acc_alu8_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_i = 1'b0;
   logic [3:0] op_i = 4'd0;
   logic [7:0] opnd_i = 8'd0;
   logic [7:0] acc_o;
   logic [4:0] flags_o;

   int n_chk = 0;
   int n_bad = 0;
   int m_acc = 0;
   int m_f   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   acc_alu8 u_acc_alu8 (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en_i),
      .op_i    (op_i),
      .opnd_i  (opnd_i),
      .acc_o   (acc_o),
      .flags_o (flags_o)
   );

   function automatic string tag_of(bit en, int op);
      if (!en) return "R2";
      case (op)
         0, 1:    return "R3";
         2:       return "R4";
         3:       return "R5";
         4, 5, 6: return "R6";
         7:       return "R7";
         8, 9:    return "R8";
         10:      return "R9";
         11:      return "R10";
         default: return "R2";
      endcase
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic step(bit en, int op, int b);
      int a, r, cy, ac, ones, t, f;
      bit szp, lo, hi;
      en_i   = en;
      op_i   = op[3:0];
      opnd_i = b[7:0];
      a   = m_acc;
      r   = a;
      f   = m_f;
      cy  = m_f & 1;
      ac  = (m_f >> 2) & 1;
      szp = 1'b0;
      if (en) begin
         case (op)
            0, 1: begin
               t   = (op == 1) ? cy : 0;
               ac  = (((a & 15) + (b & 15) + t) > 15) ? 1 : 0;
               cy  = ((a + b + t) > 255) ? 1 : 0;
               r   = (a + b + t) & 255;
               szp = 1'b1;
            end
            2, 3: begin
               cy  = (b > a) ? 1 : 0;
               ac  = ((b & 15) > (a & 15)) ? 1 : 0;
               r   = (a - b) & 255;
               szp = 1'b1;
            end
            4, 5, 6: begin
               r   = (op == 4) ? (a & b) : (op == 5) ? (a | b) : (a ^ b);
               cy  = 0;
               ac  = 0;
               szp = 1'b1;
            end
            7: r = (~a) & 255;
            8: begin r = ((a << 1) | (a >> 7)) & 255; cy = a >> 7; end
            9: begin r = (a >> 1) | ((a & 1) << 7); cy = a & 1; end
            10: begin
               lo  = ((a & 15) > 9) || (ac == 1);
               ac  = (lo && ((a & 15) > 9)) ? 1 : 0;
               t   = a + (lo ? 6 : 0);
               hi  = (((t >> 4) & 15) > 9) || (cy == 1) || (t > 255);
               r   = (t + (hi ? 'h60 : 0)) & 255;
               cy  = hi ? 1 : 0;
               szp = 1'b1;
            end
            11: r = b;
            default: ;
         endcase
         if (szp) begin
            ones = 0;
            for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
            f = ((r >> 7) << 4) | ((r == 0 ? 1 : 0) << 3) | (ac << 2)
              | (((ones % 2) == 0 ? 1 : 0) << 1) | cy;
         end else if (op == 8 || op == 9) begin
            f = (m_f & 'h1E) | cy;
         end
         if (op <= 11 && op != 3) m_acc = r;
         if (op <= 11) m_f = f;
      end
      @(posedge clk);
      @(negedge clk);
      check(tag_of(en, op), "acc", int'(acc_o), m_acc);
      if (en && szp) begin
         check("R11", "sign/zero/parity", int'(flags_o) & 'h1A, m_f & 'h1A);
         check(tag_of(en, op), "carry/aux", int'(flags_o) & 'h05, m_f & 'h05);
      end else begin
         check(tag_of(en, op), "flags", int'(flags_o), m_f);
      end
   endtask

   initial begin
      #(200000.0 * 5.0);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "reset acc", int'(acc_o), 0);
      check("R1", "reset flags", int'(flags_o), 0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R1", "acc after release", int'(acc_o), 0);

      // decimal adjust: 15 + 27 -> 42
      step(1, 11, 'h15);
      step(1, 0, 'h27);
      step(1, 10, 0);
      // 99 + 01 -> 00 with decimal carry
      step(1, 11, 'h99);
      step(1, 0, 'h01);
      step(1, 10, 0);
      // binary carry out then add with carry
      step(1, 11, 'hF0);
      step(1, 0, 'h10);
      step(1, 1, 'h05);
      // compare with larger operand, then borrow on subtract
      step(1, 11, 'h20);
      step(1, 3, 'h30);
      step(1, 2, 'h21);
      // rotates and complement
      step(1, 11, 'h81);
      step(1, 8, 0);
      step(1, 9, 0);
      step(1, 7, 0);
      // logic ops after a carry-setting op
      step(1, 0, 'hFF);
      step(1, 4, 'h0F);
      step(1, 5, 'h80);
      step(1, 6, 'hFF);
      // ignored stimulus
      step(0, 0, 'hAA);
      step(1, 12, 'h55);
      step(1, 15, 'h01);
      // aux-driven decimal adjust: 09 + 09 = 12 binary, aux set -> 18
      step(1, 11, 'h09);
      step(1, 0, 'h09);
      step(1, 10, 0);

      for (int k = 0; k < 3000; k++) begin
         step(($urandom % 8) != 0, $urandom % 16, $urandom % 256);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule